// File: doc/BRIEF.md
# Slave Arbiter with Default-Master Parking

This block sits in front of one slave of a multi-master, multi-slave interconnect. Up to sixteen masters raise request lines toward the slave. The arbiter grants exactly one of them at a time and holds that grant until the slave side signals the end of the access. The block masks out masters whose path to this slave is forbidden. When several permitted masters compete, it resolves them in round-robin order.

When nothing is pending, the arbiter leaves the slave connected to a programmable default master, or disconnects it. If the parked master then requests, the grant is already in place, so the first beat of its transfer pays no arbitration cycle. Each slave has its own instance and its own configuration register. The register holds a parking kind and a fixed-master index, so each slave's policy is independent of the others.

Top module: `slv_park_arb`

## Requirements
- R1: `gnt` has at most one bit set at any time, and `connected` is 1 exactly when a `gnt` bit is set.
- R2: A master whose `allow` bit is 0 is never given a new grant, either by arbitration or by parking.
- R3: At a decision point (no access in progress, or `xfer_end` high during an access), the arbiter takes the permitted requesters and picks the first one after the last granted master, searching in increasing index order and wrapping around. The grant is visible after the following clock edge.
- R4: While an access is in progress and `xfer_end` is low, `gnt` does not change, whatever the requests are.
- R5: If the slave is parked on a master and no access is in progress, a request from that master keeps the grant already shown in the same cycle. This holds even when other masters request too, and the grant stays held as an access.
- R6: With parking kind 0 (none) or the reserved kind 3, the slave disconnects (`gnt` = 0) at a decision point with no permitted request.
- R7: With parking kind 1 (last), the slave stays connected to the most recently granted master at a decision point with no permitted request, provided that master is permitted.
- R8: With parking kind 2 (fixed), the slave connects to the master indexed by the 4-bit fixed field at a decision point with no permitted request. If the index is not below N_MST, or that master is not permitted, the slave disconnects.
- R9: `cfg_we` high at a clock edge loads `cfg_kind` and `cfg_fix`. The edge that loads them still parks by the old setting, and the next edge parks by the new one.
- R10: After reset, the slave is disconnected, the parking kind is 0, and the last-granted record is master 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Load the configuration register |
| cfg_kind | input | 2 | Parking kind: 0 none, 1 last, 2 fixed, 3 reserved (acts as none) |
| cfg_fix | input | 4 | Fixed parking master index |
| req | input | N_MST | Per-master request lines |
| allow | input | N_MST | Per-master path permission mask |
| xfer_end | input | 1 | Current access ends this cycle |
| gnt | output | N_MST | One-hot grant |
| connected | output | 1 | Slave is connected to some master |

## Verification
A grant or parking decision taken at a decision point appears on `gnt` one edge later. The bench therefore drives inputs just after an edge and samples 1 ns after the next edge.

A configuration write needs two edges: one to load the register and one to park by it. The checks sample after the first edge to confirm the old setting still rules, and after the second to confirm the new one.

A request from the parked master needs no edge at all. That grant is checked in the same cycle as the request, before any edge.

// File: rtl/slv_park_arb.sv
module slv_park_arb #(
  parameter int N_MST = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_kind,
  input  logic [3:0]       cfg_fix,
  input  logic [N_MST-1:0] req,
  input  logic [N_MST-1:0] allow,
  input  logic             xfer_end,
  output logic [N_MST-1:0] gnt,
  output logic             connected
);
  localparam int IW = (N_MST > 1) ? $clog2(N_MST) : 1;

  logic [1:0]    kind_q;
  logic [3:0]    fix_q;
  logic [IW-1:0] cur_q, last_q, rr_idx;
  logic          conn_q, busy_q, rr_hit;

  wire [N_MST-1:0] elig   = req & allow;
  wire             arb    = !busy_q || xfer_end;
  wire             keep   = !busy_q && conn_q && elig[cur_q];
  wire [IW-1:0]    fix_ix = fix_q[IW-1:0];
  wire             fix_ok = (int'(fix_q) < N_MST) && allow[fix_ix];

  always_comb begin
    rr_hit = 1'b0;
    rr_idx = last_q;
    for (int k = 1; k <= N_MST; k++) begin
      int j;
      j = (int'(last_q) + k) % N_MST;
      if (!rr_hit && elig[j]) begin
        rr_hit = 1'b1;
        rr_idx = IW'(j);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= '0;
      fix_q  <= '0;
      cur_q  <= '0;
      last_q <= '0;
      conn_q <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      if (cfg_we) begin
        kind_q <= cfg_kind;
        fix_q  <= cfg_fix;
      end
      if (arb) begin
        if (keep) begin
          busy_q <= 1'b1;
          last_q <= cur_q;
        end else if (rr_hit) begin
          cur_q  <= rr_idx;
          last_q <= rr_idx;
          conn_q <= 1'b1;
          busy_q <= 1'b1;
        end else begin
          busy_q <= 1'b0;
          case (kind_q)
            2'd1: begin
              cur_q  <= last_q;
              conn_q <= allow[last_q];
            end
            2'd2: begin
              cur_q  <= fix_ix;
              conn_q <= fix_ok;
            end
            default: conn_q <= 1'b0;
          endcase
        end
      end
    end
  end

  for (genvar i = 0; i < N_MST; i++) begin : g_gnt
    assign gnt[i] = conn_q && (cur_q == IW'(i));
  end
  assign connected = conn_q;

  a_r1_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt) && (connected == (gnt != '0)));

  a_r2_permitted: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt != '0 && gnt != $past(gnt)) |-> (($past(allow) & gnt) != '0));

  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !xfer_end) |=> $stable(gnt));

  a_r5_parked_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && (req & allow & gnt) != '0) |=> $stable(gnt));

  a_r6_no_park: assert property (@(posedge clk) disable iff (!rst_n)
    (arb && elig == '0 && (kind_q == 2'd0 || kind_q == 2'd3)) |=> !connected);

  a_r8_bad_fix: assert property (@(posedge clk) disable iff (!rst_n)
    (arb && elig == '0 && kind_q == 2'd2 && int'(fix_q) >= N_MST) |=> !connected);
endmodule

// File: tb/slv_park_arb_tb_top.sv
module slv_park_arb_tb_top;
  localparam int N = 4;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0, xfer_end = 1'b0;
  logic [1:0] cfg_kind = '0;
  logic [3:0] cfg_fix = '0;
  logic [N-1:0] req = '0, allow = '1, gnt;
  logic connected;
  int n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  slv_park_arb #(.N_MST(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
    .cfg_fix(cfg_fix), .req(req), .allow(allow), .xfer_end(xfer_end),
    .gnt(gnt), .connected(connected));

  // {req, allow, xfer_end, expected gnt}
  localparam logic [12:0] VEC [9] = '{
    {4'b0000, 4'b1111, 1'b0, 4'b0000},  // R6 idle, none
    {4'b1111, 4'b1111, 1'b0, 4'b0010},  // R3 after 0 -> 1
    {4'b1111, 4'b1111, 1'b0, 4'b0010},  // R4 held
    {4'b1111, 4'b1111, 1'b1, 4'b0100},  // R3 after 1 -> 2
    {4'b0001, 4'b1111, 1'b1, 4'b0001},  // R3 wrap to 0
    {4'b1010, 4'b0111, 1'b1, 4'b0010},  // R2 master 3 masked
    {4'b1000, 4'b0111, 1'b1, 4'b0000},  // R2 only forbidden requests
    {4'b1000, 4'b1111, 1'b0, 4'b1000},  // R3 idle pick 3
    {4'b0000, 4'b1111, 1'b1, 4'b0000}   // R6 end, disconnect
  };

  task automatic chk(input string r, input logic [N-1:0] eg);
    n_run++;
    if (gnt !== eg || connected !== (eg != '0)) begin
      n_fail++;
      $display("FAIL %s: gnt=%b connected=%b expected gnt=%b connected=%b",
               r, gnt, connected, eg, (eg != '0));
    end
  endtask

  task automatic step;
    @(posedge clk);
    #1;
  endtask

  task automatic wr_cfg(input logic [1:0] k, input logic [3:0] f);
    cfg_we = 1'b1; cfg_kind = k; cfg_fix = f;
    step();
    cfg_we = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    step(); step();
    chk("R10 reset", 4'b0000);
    rst_n = 1'b1;
    step();
    chk("R10 after release", 4'b0000);

    for (int v = 0; v < 9; v++) begin
      req = VEC[v][12:9]; allow = VEC[v][8:5]; xfer_end = VEC[v][4];
      step();
      chk($sformatf("R3 vector %0d", v), VEC[v][3:0]);
    end
    req = '0; xfer_end = 1'b0; allow = '1;

    wr_cfg(2'd1, 4'd0);
    chk("R9 old kind on load edge", 4'b0000);
    step();
    chk("R7 park on last (3)", 4'b1000);

    req = 4'b1001;
    #1;
    chk("R5 parked grant same cycle", 4'b1000);
    step();
    chk("R5 parked master keeps grant", 4'b1000);
    req = 4'b0001; xfer_end = 1'b1;
    step();
    chk("R3 boundary after 3 -> 0", 4'b0001);
    req = 4'b0000;
    step();
    chk("R7 park on last (0)", 4'b0001);
    xfer_end = 1'b0;

    wr_cfg(2'd2, 4'd2);
    chk("R9 still last kind", 4'b0001);
    step();
    chk("R8 fixed park on 2", 4'b0100);
    allow = 4'b1011;
    step();
    chk("R8 fixed master forbidden", 4'b0000);
    allow = 4'b1111;
    step();
    chk("R8 fixed master permitted again", 4'b0100);
    wr_cfg(2'd2, 4'd5);
    chk("R9 old index on load edge", 4'b0100);
    step();
    chk("R8 index out of range", 4'b0000);

    wr_cfg(2'd2, 4'd1);
    step();
    chk("R8 fixed park on 1", 4'b0010);
    wr_cfg(2'd3, 4'd1);
    chk("R9 fixed still on load edge", 4'b0010);
    step();
    chk("R6 reserved kind disconnects", 4'b0000);

    wr_cfg(2'd1, 4'd0);
    step();
    chk("R7 park on last (0) again", 4'b0001);
    allow = 4'b1110;
    step();
    chk("R7 last master forbidden", 4'b0000);
    allow = 4'b1111;

    req = 4'b0100;
    step();
    chk("R3 grant before reset", 4'b0100);
    rst_n = 1'b0;
    #1;
    chk("R10 reset mid access", 4'b0000);
    req = '0;
    step();
    rst_n = 1'b1;
    step();
    chk("R10 reset restores kind none", 4'b0000);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule